// File: doc/BRIEF.md
# External memory bus strobe sequencer

This block produces the control timing of the external memory bus of a small 8-bit controller core whose machine cycle lasts twelve oscillator periods (six states of two phases each). In every machine cycle it drives the address-latch strobe and the active-low code-read strobe. It presents addresses on a shared low address/data port, drives a separate high-address port, and generates the active-low read and write strobes for external data memory. The block's clock is the oscillator clock.

The core issues one request per machine cycle. A request is a plain fetch, a code-table read, an external data read or an external data write. Data requests state whether they use an 8-bit or a 16-bit address. A data access occupies two machine cycles, and the block does not take a new request between them. Two mode inputs are captured with each request. One suppresses the latch strobe outside data-move and table-read cycles. The other marks execution from external code memory, which overrides that suppression.

Top module: `xmb_strobe_seq`

## Requirements
- R1: A machine cycle is 12 clock periods, numbered 0 to 11, and `mc_end` is high in period 11. Each latch pulse is high for exactly two periods, starting in period 1 (first slot) or period 7 (second slot). All strobes are inactive while reset is asserted.
- R2: In a plain fetch cycle with external execution, `psen_n` is low in periods 3–5 and 9–11, which gives two pulses. With internal execution, a plain fetch produces no `psen_n` pulse.
- R3: A data access spans two machine cycles. The first cycle has two latch pulses. The second cycle omits the first-slot pulse and keeps the second-slot pulse.
- R4: With external execution, a data access gives one `psen_n` pulse in each of its two cycles, so two code-read pulses are omitted.
- R5: With `ale_off` set and internal execution, a plain fetch cycle has no latch pulse. Data-access cycles and table-read cycles still pulse as in R3 and R12.
- R6: With `ext_exec` set, `ale_off` has no effect and every cycle pulses as in R1–R3.
- R7: During an address phase (periods 0–2 of a slot that accesses the bus, and periods 6–8 of a slot that accesses the bus), `ad_oe` is high and `ad_out` carries the low address byte, which is valid while the latch strobe is high. The first-slot address is `req_pc`. The second-slot address is `req_pc`+1 for fetches and `req_addr` for table and data slots. `ad_oe` is low while `psen_n` is low.
- R8: `hi_out` carries the upper address byte for fetches, table reads and 16-bit data accesses. For 8-bit data accesses (`req_wide`=0), it carries `p2_val` from the second slot of the first cycle through the first half of the second cycle.
- R9: `rd_n` (read) or `wr_n` (write) is low for 8 periods, from period 10 of the first data cycle through period 5 of the second data cycle, and falls once per access. A write drives `req_wdata` with `ad_oe` high during the strobe. A read leaves `ad_oe` low during the strobe and for at least the period before it.
- R10: On a read, the byte on `ad_in` in the last strobe period is presented on `rd_data`, and `rd_valid` is high for the one following period.
- R11: A request (`req_op` 0=fetch, 1=table read, 2=data read, 3=data write) together with its operands and mode inputs is taken at the end of period 11 while `accept` is high. `accept` is low at the end of the first data cycle, and inputs applied then are ignored.
- R12: A table-read cycle pulses the latch strobe in both slots regardless of `ale_off`. Its second slot always reads external code, with `psen_n` low in periods 9–11 at address `req_addr`. Its first slot is an opcode fetch that follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| req_op | input | 2 | Request kind: 0 fetch, 1 table read, 2 data read, 3 data write |
| req_wide | input | 1 | Data access uses a 16-bit address |
| req_addr | input | 16 | Data or table address |
| req_pc | input | 16 | Code address of the opcode fetch |
| req_wdata | input | 8 | Byte to write |
| p2_val | input | 8 | High-port register value used by 8-bit data accesses |
| ale_off | input | 1 | Suppress the latch strobe outside data-move and table cycles |
| ext_exec | input | 1 | Code executes from external memory |
| ad_in | input | 8 | Byte read from the shared port |
| accept | output | 1 | Request is taken at this clock edge |
| mc_end | output | 1 | Last period of the machine cycle |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Code-read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| hi_out | output | 8 | High-address port |
| rd_data | output | 8 | Captured read byte |
| rd_valid | output | 1 | `rd_data` is fresh |

## Verification
The bench counts latch pulses and code-read pulses in each machine cycle for fetch, read, write and table sequences under all four settings of the two mode bits. A design that forgot the omitted pulses, or that obeyed the latch-disable bit in external-execution mode, shows up as a wrong count. The bench compares the high port during the data strobe for 8-bit and 16-bit accesses, so a design that picks the wrong source for the high byte is caught. It also changes the request inputs between the two data cycles: a design that re-samples them corrupts the second cycle. Write data, read capture and strobe counts are checked on every access.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int STATES  = 6;
  localparam int PHASES  = 2;
  localparam int MC_LEN  = STATES * PHASES;
  localparam int HALF    = MC_LEN / 2;
  localparam int IDX_W   = $clog2(MC_LEN);
  // latch pulse starts at phase 2 of state 1 and of state 4
  localparam int ALE_A   = 1;
  localparam int ALE_B   = ALE_A + 3 * PHASES;
  localparam int STB_ON  = MC_LEN - PHASES;   // strobe start in first data cycle
  localparam int STB_OFF = HALF;              // strobe ends before this in second

  typedef enum logic [1:0] {
    XOP_FETCH  = 2'd0,
    XOP_TABLE  = 2'd1,
    XOP_DREAD  = 2'd2,
    XOP_DWRITE = 2'd3
  } xop_e;

  typedef enum logic [1:0] {
    ROLE_PLAIN = 2'd0,
    ROLE_TABLE = 2'd1,
    ROLE_DATA1 = 2'd2,
    ROLE_DATA2 = 2'd3
  } role_e;

  function automatic logic in_slot_b(input logic [IDX_W-1:0] i);
    return int'(i) >= HALF;
  endfunction

  function automatic logic in_ale_win(input logic [IDX_W-1:0] i);
    return (int'(i) >= ALE_A && int'(i) < ALE_A + PHASES) ||
           (int'(i) >= ALE_B && int'(i) < ALE_B + PHASES);
  endfunction

  function automatic logic in_addr_win(input logic [IDX_W-1:0] i);
    return (int'(i) >= ALE_A - 1 && int'(i) < ALE_A + PHASES) ||
           (int'(i) >= ALE_B - 1 && int'(i) < ALE_B + PHASES);
  endfunction

  function automatic logic in_code_win(input logic [IDX_W-1:0] i);
    return (int'(i) >= ALE_A + PHASES && int'(i) < HALF) ||
           (int'(i) >= ALE_B + PHASES && int'(i) < MC_LEN);
  endfunction

  function automatic logic in_strobe_win(input role_e r, input logic [IDX_W-1:0] i);
    return (r == ROLE_DATA1 && int'(i) >= STB_ON) ||
           (r == ROLE_DATA2 && int'(i) < STB_OFF);
  endfunction

  function automatic logic in_data_hi_win(input role_e r, input logic [IDX_W-1:0] i);
    return (r == ROLE_DATA1 && int'(i) >= HALF) ||
           (r == ROLE_DATA2 && int'(i) < HALF);
  endfunction

  function automatic role_e role_of(input xop_e op);
    case (op)
      XOP_TABLE:              return ROLE_TABLE;
      XOP_DREAD, XOP_DWRITE:  return ROLE_DATA1;
      default:                return ROLE_PLAIN;
    endcase
  endfunction
endpackage

// File: rtl/xmb_phase_gen.sv
module xmb_phase_gen
  import xmb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [IDX_W-1:0] idx,
  output logic             mc_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(MC_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= '0;
    else if (idx == LAST) idx <= '0;
    else                 idx <= idx + 1'b1;
  end

  assign mc_end = (idx == LAST);

  a_r1_idx_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    mc_end |=> (idx == '0));
endmodule

// File: rtl/xmb_cycle_ctl.sv
module xmb_cycle_ctl
  import xmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mc_end,
  input  logic [1:0]    req_op,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_pc,
  input  logic [DW-1:0] req_wdata,
  input  logic [HW-1:0] p2_val,
  input  logic          ale_off,
  input  logic          ext_exec,
  output logic          accept,
  output role_e         role,
  output logic          r_write,
  output logic          r_wide,
  output logic [AW-1:0] r_addr,
  output logic [AW-1:0] r_pc,
  output logic [DW-1:0] r_wdata,
  output logic [HW-1:0] r_p2,
  output logic          r_aoff,
  output logic          r_ext
);
  // a data access keeps its operands for the second cycle
  assign accept = mc_end && (role != ROLE_DATA1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role    <= ROLE_PLAIN;
      r_write <= 1'b0;
      r_wide  <= 1'b0;
      r_addr  <= '0;
      r_pc    <= '0;
      r_wdata <= '0;
      r_p2    <= '0;
      r_aoff  <= 1'b0;
      r_ext   <= 1'b0;
    end else if (mc_end) begin
      if (role == ROLE_DATA1) begin
        role <= ROLE_DATA2;
      end else begin
        role    <= role_of(xop_e'(req_op));
        r_write <= (xop_e'(req_op) == XOP_DWRITE);
        r_wide  <= req_wide;
        r_addr  <= req_addr;
        r_pc    <= req_pc;
        r_wdata <= req_wdata;
        r_p2    <= p2_val;
        r_aoff  <= ale_off;
        r_ext   <= ext_exec;
      end
    end
  end

  a_r3_second_cycle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_end && role == ROLE_DATA1) |=> (role == ROLE_DATA2));
  a_r11_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_end && role == ROLE_DATA1) |=> ($stable(r_addr) && $stable(r_pc) && $stable(r_write)));
endmodule

// File: rtl/xmb_strobe_gen.sv
module xmb_strobe_gen
  import xmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  role_e            role,
  input  logic             r_write,
  input  logic             r_wide,
  input  logic [AW-1:0]    r_addr,
  input  logic [AW-1:0]    r_pc,
  input  logic [DW-1:0]    r_wdata,
  input  logic [HW-1:0]    r_p2,
  input  logic             r_aoff,
  input  logic             r_ext,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  output logic [HW-1:0]    hi_out
);
  function automatic logic [AW-1:0] code_next(input logic [AW-1:0] pc);
    return pc + AW'(1);
  endfunction

  // named internal events, used by the assertions
  logic          slot_b, code_a, code_b, slot_code, slot_bus;
  logic          ale_ok, slot_has_ale, strobe, addr_drive, data_hi;
  logic [AW-1:0] slot_addr;

  always_comb begin
    slot_b       = in_slot_b(idx);
    code_a       = (role != ROLE_DATA2) && r_ext;
    code_b       = ((role == ROLE_PLAIN) || (role == ROLE_DATA2)) ? r_ext
                                                                 : (role == ROLE_TABLE);
    slot_code    = slot_b ? code_b : code_a;
    slot_bus     = slot_code || (slot_b && role == ROLE_DATA1);
    ale_ok       = r_ext || !r_aoff || (role != ROLE_PLAIN);
    slot_has_ale = slot_b || (role != ROLE_DATA2);
    if (!slot_b)
      slot_addr = r_pc;
    else if (role == ROLE_PLAIN || role == ROLE_DATA2)
      slot_addr = code_next(r_pc);
    else
      slot_addr = r_addr;
    strobe     = in_strobe_win(role, idx);
    addr_drive = in_addr_win(idx) && slot_bus;
    data_hi    = in_data_hi_win(role, idx);
  end

  assign ale    = in_ale_win(idx) && ale_ok && slot_has_ale;
  assign psen_n = !(in_code_win(idx) && slot_code);
  assign rd_n   = !(strobe && !r_write);
  assign wr_n   = !(strobe && r_write);
  assign ad_oe  = addr_drive || (strobe && r_write);
  assign ad_out = addr_drive            ? slot_addr[DW-1:0] :
                  (strobe && r_write)   ? r_wdata           : '0;
  assign hi_out = (data_hi && !r_wide)  ? r_p2 :
                  data_hi               ? r_addr[AW-1:DW] : slot_addr[AW-1:DW];

  a_r1_ale_rises_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |-> (int'(idx) == ALE_A || int'(idx) == ALE_B));
  a_r1_ale_two_periods: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ale) |=> ale);
  a_r7_code_read_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
    !psen_n |-> !ad_oe);
  a_r9_one_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  a_r9_bus_free_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> (!ad_oe && !$past(ad_oe)));
  a_r9_write_drives_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);
endmodule

// File: rtl/xmb_rd_capture.sv
module xmb_rd_capture
  import xmb_pkg::*;
#(
  parameter int DW = 8
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  role_e            role,
  input  logic             r_write,
  input  logic [DW-1:0]    ad_in,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  logic take;
  assign take = (role == ROLE_DATA2) && !r_write && (int'(idx) == STB_OFF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= take;
      if (take) rd_data <= ad_in;
    end
  end

  a_r10_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/xmb_strobe_seq.sv
module xmb_strobe_seq
  import xmb_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HW = AW - DW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    req_op,
  input  logic          req_wide,
  input  logic [AW-1:0] req_addr,
  input  logic [AW-1:0] req_pc,
  input  logic [DW-1:0] req_wdata,
  input  logic [HW-1:0] p2_val,
  input  logic          ale_off,
  input  logic          ext_exec,
  input  logic [DW-1:0] ad_in,
  output logic          accept,
  output logic          mc_end,
  output logic          ale,
  output logic          psen_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] hi_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [IDX_W-1:0] idx;
  role_e            role;
  logic             r_write, r_wide, r_aoff, r_ext;
  logic [AW-1:0]    r_addr, r_pc;
  logic [DW-1:0]    r_wdata;
  logic [HW-1:0]    r_p2;

  xmb_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .idx(idx), .mc_end(mc_end)
  );

  xmb_cycle_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .mc_end(mc_end),
    .req_op(req_op), .req_wide(req_wide), .req_addr(req_addr), .req_pc(req_pc),
    .req_wdata(req_wdata), .p2_val(p2_val), .ale_off(ale_off), .ext_exec(ext_exec),
    .accept(accept), .role(role), .r_write(r_write), .r_wide(r_wide),
    .r_addr(r_addr), .r_pc(r_pc), .r_wdata(r_wdata), .r_p2(r_p2),
    .r_aoff(r_aoff), .r_ext(r_ext)
  );

  xmb_strobe_gen #(.AW(AW), .DW(DW)) u_stb (
    .clk(clk), .rst_n(rst_n), .idx(idx), .role(role), .r_write(r_write),
    .r_wide(r_wide), .r_addr(r_addr), .r_pc(r_pc), .r_wdata(r_wdata),
    .r_p2(r_p2), .r_aoff(r_aoff), .r_ext(r_ext),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out)
  );

  xmb_rd_capture #(.DW(DW)) u_rdc (
    .clk(clk), .rst_n(rst_n), .idx(idx), .role(role), .r_write(r_write),
    .ad_in(ad_in), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  a_r10_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!rd_n) && rd_n));
  a_r11_no_accept_after_first_data: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_op[1]) |=> (!accept until_with mc_end));
endmodule

// File: tb/xmb_strobe_seq_tb_top.sv
`timescale 1ns/1ps
module xmb_strobe_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  req_op = '0;
  logic        req_wide = 1'b0;
  logic [15:0] req_addr = '0, req_pc = '0;
  logic [7:0]  req_wdata = '0, p2_val = '0, ad_in = '0;
  logic        ale_off = 1'b0, ext_exec = 1'b0;
  logic        accept, mc_end, ale, psen_n, rd_n, wr_n, ad_oe, rd_valid;
  logic [7:0]  ad_out, hi_out, rd_data;

  always #2 clk = ~clk;

  xmb_strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_op(req_op), .req_wide(req_wide),
    .req_addr(req_addr), .req_pc(req_pc), .req_wdata(req_wdata), .p2_val(p2_val),
    .ale_off(ale_off), .ext_exec(ext_exec), .ad_in(ad_in),
    .accept(accept), .mc_end(mc_end), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  typedef struct {
    int ale_n, psen_n, rdf, wrf;
    bit acc, chk_a, oe, dat, wr, rd;
    logic [7:0] hi, ad, dhi, wd, rb;
  } exp_t;

  exp_t  q[$];
  string qtag[$];

  // scoreboard driver: waits for an accepting edge, drives, pushes expectations
  task automatic issue(input logic [1:0] op, input bit wide, input logic [15:0] addr,
                       input logic [15:0] pc, input logic [7:0] wd, input logic [7:0] p2,
                       input logic [7:0] rb, input bit ext, input bit aoff, input string tag);
    exp_t e, e2;
    logic [15:0] pc1;
    do @(negedge clk); while (!(mc_end && accept));
    req_op = op; req_wide = wide; req_addr = addr; req_pc = pc; req_wdata = wd;
    p2_val = p2; ext_exec = ext; ale_off = aoff; ad_in = rb;
    #1;
    pc1 = pc + 16'd1;
    e = '{default: '0};
    e.acc = 1'b1;
    case (op)
      2'd0: begin // plain fetch: R1 R2 R5 R6
        e.ale_n = (ext || !aoff) ? 2 : 0;
        e.psen_n = ext ? 2 : 0;
        e.chk_a = (e.ale_n != 0); e.oe = ext; e.hi = pc1[15:8]; e.ad = pc1[7:0];
        q.push_back(e); qtag.push_back(tag);
      end
      2'd1: begin // table read: R12
        e.ale_n = 2; e.psen_n = ext ? 2 : 1;
        e.chk_a = 1'b1; e.oe = 1'b1; e.hi = addr[15:8]; e.ad = addr[7:0];
        q.push_back(e); qtag.push_back(tag);
      end
      default: begin // data access: R3 R4 R8 R9 R10 R11
        e.ale_n = 2; e.psen_n = ext ? 1 : 0; e.acc = 1'b0;
        e.rdf = (op == 2'd2); e.wrf = (op == 2'd3);
        e.chk_a = 1'b1; e.oe = 1'b1;
        e.hi = wide ? addr[15:8] : p2; e.ad = addr[7:0];
        e.dat = 1'b1; e.dhi = e.hi; e.wr = (op == 2'd3); e.wd = wd;
        e2 = '{default: '0};
        e2.acc = 1'b1; e2.ale_n = 1; e2.psen_n = ext ? 1 : 0;
        e2.chk_a = 1'b1; e2.oe = ext; e2.hi = pc1[15:8]; e2.ad = pc1[7:0];
        e2.dat = 1'b1; e2.dhi = e.dhi; e2.wr = e.wr; e2.wd = wd;
        e2.rd = (op == 2'd2); e2.rb = rb;
        q.push_back(e); qtag.push_back(tag);
        q.push_back(e2); qtag.push_back(tag);
        @(negedge clk);
        // R11: garbage while the access is in flight must be ignored
        req_op = 2'd0; req_wide = ~wide; req_addr = 16'hDEAD; req_pc = 16'hFFF0;
        req_wdata = 8'hEE; p2_val = 8'h11; ext_exec = ~ext; ale_off = ~aoff;
      end
    endcase
  endtask

  // monitor: per machine cycle counters, compared at the cycle's last period
  int   c_ale, c_psen, c_rd, c_wr, c_aleh;
  bit   p_ale, p_psen_n, p_rd_n, p_wr_n, cap_oe, d_seen, w_oe, rv_seen;
  logic [7:0] cap_hi, cap_ad, cap_dhi, cap_wd, cap_rb;

  task automatic clear_mon();
    c_ale = 0; c_psen = 0; c_rd = 0; c_wr = 0; c_aleh = 0;
    cap_oe = 0; d_seen = 0; w_oe = 1; rv_seen = 0;
    cap_hi = '0; cap_ad = '0; cap_dhi = '0; cap_wd = '0; cap_rb = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t  e;
      string t;
      if (ale && !p_ale) c_ale++;
      if (ale) begin
        c_aleh++; cap_hi = hi_out; cap_ad = ad_out; cap_oe = ad_oe;
      end
      if (!psen_n && p_psen_n) c_psen++;
      if (!rd_n && p_rd_n) c_rd++;
      if (!wr_n && p_wr_n) c_wr++;
      if (!rd_n || !wr_n) begin
        d_seen = 1; cap_dhi = hi_out;
        if (!wr_n) begin cap_wd = ad_out; w_oe = w_oe && ad_oe; end
      end
      if (rd_valid) begin rv_seen = 1; cap_rb = rd_data; end
      if (mc_end) begin
        if (q.size() != 0) begin
          e = q.pop_front(); t = qtag.pop_front();
          check({t, " latch pulses"}, c_ale, e.ale_n);
          check("R1 latch width", c_aleh, 2 * e.ale_n);
          check({t, " code-read pulses"}, c_psen, e.psen_n);
          check("R9 read strobe count", c_rd, e.rdf);
          check("R9 write strobe count", c_wr, e.wrf);
          check("R11 accept", accept, e.acc);
          if (e.chk_a) begin
            check("R8 high port at latch", cap_hi, e.hi);
            check("R7 port enable at latch", cap_oe, e.oe);
            if (e.oe) check("R7 low address at latch", cap_ad, e.ad);
          end
          if (e.dat) begin
            check("R9 strobe seen", d_seen, 1);
            check("R8 high port during strobe", cap_dhi, e.dhi);
            if (e.wr) begin
              check("R9 write data", cap_wd, e.wd);
              check("R9 write enable", w_oe, 1);
            end
          end
          check("R10 read valid", rv_seen, e.rd);
          if (e.rd) check("R10 read data", cap_rb, e.rb);
        end
        clear_mon();
      end
    end else clear_mon();
    p_ale = ale; p_psen_n = psen_n; p_rd_n = rd_n; p_wr_n = wr_n;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset ale", ale, 0);
    check("R1 reset psen_n", psen_n, 1);
    check("R1 reset rd_n", rd_n, 1);
    check("R1 reset wr_n", wr_n, 1);
    check("R1 reset ad_oe", ad_oe, 0);
    check("R1 reset rd_valid", rd_valid, 0);
    rst_n = 1'b1;
    // external execution, latch enabled
    issue(2'd0, 0, 16'h0000, 16'h1234, 8'h00, 8'h00, 8'h00, 1, 0, "R1 R2");
    issue(2'd0, 0, 16'h0000, 16'h12FF, 8'h00, 8'h00, 8'h00, 1, 0, "R2");
    issue(2'd2, 1, 16'hA5C3, 16'h2000, 8'h00, 8'h77, 8'h9B, 1, 0, "R3 R4");
    issue(2'd3, 0, 16'h00E1, 16'h2100, 8'h5A, 8'h3C, 8'h00, 1, 0, "R3 R4");
    issue(2'd1, 0, 16'h4F10, 16'h2200, 8'h00, 8'h00, 8'h00, 1, 0, "R12");
    // external execution with latch disable: R6
    issue(2'd0, 0, 16'h0000, 16'h3000, 8'h00, 8'h00, 8'h00, 1, 1, "R6");
    issue(2'd2, 0, 16'h0042, 16'h3001, 8'h00, 8'hC8, 8'h61, 1, 1, "R6 R3");
    // internal execution, latch enabled
    issue(2'd0, 0, 16'h0000, 16'h0400, 8'h00, 8'h00, 8'h00, 0, 0, "R2");
    issue(2'd3, 1, 16'h8899, 16'h0401, 8'hC3, 8'h00, 8'h00, 0, 0, "R3");
    // internal execution, latch disabled: R5
    issue(2'd0, 0, 16'h0000, 16'h0500, 8'h00, 8'h00, 8'h00, 0, 1, "R5");
    issue(2'd0, 0, 16'h0000, 16'h0501, 8'h00, 8'h00, 8'h00, 0, 1, "R5");
    issue(2'd2, 0, 16'h0013, 16'h0502, 8'h00, 8'hB4, 8'hE7, 0, 1, "R5 R3");
    issue(2'd1, 0, 16'h7733, 16'h0503, 8'h00, 8'h00, 8'h00, 0, 1, "R5 R12");
    issue(2'd3, 0, 16'h00FE, 16'h0504, 8'h81, 8'h2D, 8'h00, 0, 1, "R5 R3");
    issue(2'd0, 0, 16'h0000, 16'h0505, 8'h00, 8'h00, 8'h00, 0, 1, "R5");
    issue(2'd0, 0, 16'h0000, 16'h0506, 8'h00, 8'h00, 8'h00, 1, 0, "R2");
    while (q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule